// File: doc/BRIEF.md
# Expansion Bus Read Controller

This block runs read cycles on an external static-memory or expansion bus for one internal requester. A request gives a byte address, a single/burst flag and a burst length. The block chooses one of six active-low chip selects from the top address bits and drives the address and an active-low output enable. It returns each captured 32-bit word with a one-cycle response pulse.

Every chip select has its own timing settings: a wait count for the first (non-sequential) word, a wait count for the following (sequential) words, and a sequential-enable bit. Accesses can be lengthened only in whole clock periods, by programmed wait states, by the external ready line, or by both. The ready line is sampled on the falling clock edge. During a burst, chip select and output enable stay low from the first word to the last. A single read releases them when it completes. Requests aimed at the two unused address regions are refused with an error response and cause no bus activity.

Top module: `exp_rd_ctrl`

## Requirements
- R1: After reset, all six `bus_cs_n` bits and `bus_oe_n` are high, `rsp_valid` is low and `req_ready` is high.
- R2: Address bits [27:25] select the chip select: a value c in 0..5 drives `bus_cs_n[c]` low, and at most one chip select is ever low.
- R3: A request whose address bits [27:25] are 6 or 7 is answered in the cycle after acceptance with `rsp_valid`, `rsp_err` and `rsp_last` all high. No chip select or output enable goes low.
- R4: With ready held high, the first word of a request completes W+1 cycles after the accepting edge, where W is the non-sequential wait count of the selected chip select (field c*4+3:c*4 of `cfg_nseq_ws`). Its data appears with `rsp_valid` in the next cycle.
- R5: `bus_rdy` is sampled on each falling clock edge. If it is low at the falling edge before a word would complete, completion moves one cycle later. A first word with ready low on the first N falling edges completes max(W,N)+1 cycles after acceptance.
- R6: When `cfg_seq_en[c]` is set, each later word of a burst completes S+1 cycles after the previous one, with no idle cycle, where S is field c*4+3:c*4 of `cfg_seq_ws`.
- R7: When `cfg_seq_en[c]` is clear, each later word of a burst completes W+2 cycles after the previous one: one idle cycle followed by a full non-sequential access.
- R8: Throughout a burst, including the idle cycles between words, the selected chip select and `bus_oe_n` stay low without toggling.
- R9: In the cycle after the final word completes, all chip selects and `bus_oe_n` are high, so back-to-back single reads toggle them.
- R10: A burst (`req_burst`=1) transfers `req_len`+1 words from addresses that rise by 4 per word. A single read (`req_burst`=0) transfers one word whatever `req_len` holds. Each word's `rsp_data` is the bus data present at its completing edge, and `rsp_last` marks the final word.
- R11: `req_ready` is high only while no access is in progress, and a request is accepted on a rising edge where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nseq_ws | input | 24 | Non-sequential wait count, 4 bits per chip select |
| cfg_seq_ws | input | 24 | Sequential wait count, 4 bits per chip select |
| cfg_seq_en | input | 6 | Sequential-access enable per chip select |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | 28 | Byte address of first word |
| req_burst | input | 1 | 1 = burst read, 0 = single read |
| req_len | input | 4 | Burst word count minus one |
| rsp_valid | output | 1 | One-cycle pulse per returned word |
| rsp_data | output | 32 | Captured read word |
| rsp_err | output | 1 | Request targeted an unmapped region |
| rsp_last | output | 1 | Final word of the request |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_addr | output | 28 | Bus address |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_data_in | input | 32 | Read data from the bus |
| bus_rdy | input | 1 | Device ready, sampled on falling edges |

## Verification
The hardest case to reach from the ports is the overlap between a ready stall and the programmed wait count on the first word of a burst, followed by sequential or idle-separated later words. It is hard because the completion edge depends on two independent counts and on whether a falling edge landed inside the stall. The bench drives ready low on a fixed number of falling edges right after acceptance. It sweeps that number across, below and above the wait count, for both sequential settings and several burst lengths. For each run it computes every word's completion cycle as max(W,N)+1 plus a fixed per-word step, and compares the result cycle by cycle.

// File: rtl/exp_rd_pkg.sv
`timescale 1ns/1ps
package exp_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_GAP  = 2'd2
  } rd_state_e;

  // Number of cycles from one word's completion to the next inside a burst.
  function automatic int unsigned word_spacing(input logic seq, input int unsigned nseq_ws,
                                               input int unsigned seq_ws);
    return seq ? (seq_ws + 1) : (nseq_ws + 2);
  endfunction

  // A region index is mapped when it names an existing chip select.
  function automatic logic region_mapped(input int unsigned sel, input int unsigned ncs);
    return sel < ncs;
  endfunction

endpackage

// File: rtl/exp_rd_decode.sv
`timescale 1ns/1ps
module exp_rd_decode
  import exp_rd_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int SEL_W  = 3
) (
  input  logic [SEL_W-1:0] sel_bits,
  output logic [SEL_W-1:0] sel_idx,
  output logic             sel_hit
);
  assign sel_idx = sel_bits;
  assign sel_hit = region_mapped(int'(sel_bits), NUM_CS);
endmodule

// File: rtl/exp_rd_cfgsel.sv
`timescale 1ns/1ps
module exp_rd_cfgsel #(
  parameter int NUM_CS = 6,
  parameter int WS_W   = 4,
  parameter int SEL_W  = 3
) (
  input  logic [NUM_CS*WS_W-1:0] cfg_nseq_ws,
  input  logic [NUM_CS*WS_W-1:0] cfg_seq_ws,
  input  logic [NUM_CS-1:0]      cfg_seq_en,
  input  logic [SEL_W-1:0]       idx,
  output logic [WS_W-1:0]        nseq_ws,
  output logic [WS_W-1:0]        seq_ws,
  output logic                   seq_en
);
  logic [WS_W-1:0] n_arr [NUM_CS];
  logic [WS_W-1:0] s_arr [NUM_CS];

  for (genvar c = 0; c < NUM_CS; c++) begin : g_unpack
    assign n_arr[c] = cfg_nseq_ws[c*WS_W +: WS_W];
    assign s_arr[c] = cfg_seq_ws[c*WS_W +: WS_W];
  end

  always_comb begin
    nseq_ws = '0;
    seq_ws  = '0;
    seq_en  = 1'b0;
    for (int c = 0; c < NUM_CS; c++) begin
      if (int'(idx) == c) begin
        nseq_ws = n_arr[c];
        seq_ws  = s_arr[c];
        seq_en  = cfg_seq_en[c];
      end
    end
  end
endmodule

// File: rtl/exp_rd_wait.sv
`timescale 1ns/1ps
module exp_rd_wait #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_rdy,
  input  logic            load,
  input  logic [WS_W-1:0] load_val,
  input  logic            run,
  output logic            wait_zero,
  output logic            rdy_fall
);
  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // Ready is captured half a cycle before the edge that may end the word.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rdy_fall <= 1'b0;
    else        rdy_fall <= bus_rdy;
  end

  assign wait_zero = (cnt_q == '0);
endmodule

// File: rtl/exp_rd_csdrv.sv
`timescale 1ns/1ps
module exp_rd_csdrv #(
  parameter int NUM_CS = 6,
  parameter int SEL_W  = 3
) (
  input  logic              active,
  input  logic [SEL_W-1:0]  cs_idx,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign cs_n[c] = !(active && (int'(cs_idx) == c));
  end
endmodule

// File: rtl/exp_rd_ctrl.sv
`timescale 1ns/1ps
module exp_rd_ctrl
  import exp_rd_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  parameter int WS_W   = 4,
  parameter int LEN_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CS*WS_W-1:0] cfg_nseq_ws,
  input  logic [NUM_CS*WS_W-1:0] cfg_seq_ws,
  input  logic [NUM_CS-1:0]      cfg_seq_en,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_burst,
  input  logic [LEN_W-1:0]       req_len,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic                   rsp_err,
  output logic                   rsp_last,
  output logic [NUM_CS-1:0]      bus_cs_n,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic                   bus_oe_n,
  input  logic [DATA_W-1:0]      bus_data_in,
  input  logic                   bus_rdy
);
  localparam int SEL_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int WORD_BYTES = DATA_W / 8;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(WORD_BYTES);
  endfunction

  function automatic logic [LEN_W-1:0] words_after_first(input logic burst,
                                                         input logic [LEN_W-1:0] len);
    return burst ? len : '0;
  endfunction

  rd_state_e         state_q;
  logic [SEL_W-1:0]  cs_idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              seq_q;

  logic [SEL_W-1:0]  dec_idx;
  logic              dec_hit;
  logic [SEL_W-1:0]  cfg_idx;
  logic [WS_W-1:0]   sel_nseq;
  logic [WS_W-1:0]   sel_seq;
  logic              sel_seq_en;

  // Named internal events (used by the bound checker).
  logic              accept;
  logic              acc_active;
  logic              wait_zero;
  logic              rdy_fall;
  logic              word_done;
  logic              last_done;
  logic              ctr_load;
  logic [WS_W-1:0]   ctr_val;
  logic              bus_active;

  exp_rd_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) dec_i (
    .sel_bits (req_addr[ADDR_W-1 -: SEL_W]),
    .sel_idx  (dec_idx),
    .sel_hit  (dec_hit)
  );

  assign cfg_idx = (state_q == ST_IDLE) ? dec_idx : cs_idx_q;

  exp_rd_cfgsel #(.NUM_CS(NUM_CS), .WS_W(WS_W), .SEL_W(SEL_W)) cfg_i (
    .cfg_nseq_ws (cfg_nseq_ws),
    .cfg_seq_ws  (cfg_seq_ws),
    .cfg_seq_en  (cfg_seq_en),
    .idx         (cfg_idx),
    .nseq_ws     (sel_nseq),
    .seq_ws      (sel_seq),
    .seq_en      (sel_seq_en)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign acc_active = (state_q == ST_ACC);
  assign word_done  = acc_active && wait_zero && rdy_fall;
  assign last_done  = word_done && (left_q == '0);

  always_comb begin
    ctr_load = 1'b0;
    ctr_val  = sel_nseq;
    if (accept && dec_hit) begin
      ctr_load = 1'b1;
      ctr_val  = sel_nseq;
    end else if (word_done && !last_done) begin
      ctr_load = 1'b1;
      ctr_val  = seq_q ? sel_seq : sel_nseq;
    end
  end

  exp_rd_wait #(.WS_W(WS_W)) wait_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rdy   (bus_rdy),
    .load      (ctr_load),
    .load_val  (ctr_val),
    .run       (acc_active),
    .wait_zero (wait_zero),
    .rdy_fall  (rdy_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cs_idx_q <= '0;
      addr_q   <= '0;
      left_q   <= '0;
      seq_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept && dec_hit) begin
            state_q  <= ST_ACC;
            cs_idx_q <= dec_idx;
            addr_q   <= req_addr;
            left_q   <= words_after_first(req_burst, req_len);
            seq_q    <= sel_seq_en;
          end
        end
        ST_ACC: begin
          if (last_done) begin
            state_q <= ST_IDLE;
          end else if (word_done) begin
            left_q  <= left_q - 1'b1;
            addr_q  <= step_addr(addr_q);
            state_q <= seq_q ? ST_ACC : ST_GAP;
          end
        end
        ST_GAP:  state_q <= ST_ACC;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && !dec_hit) begin
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b1;
        rsp_last  <= 1'b1;
        rsp_data  <= '0;
      end else if (word_done) begin
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b0;
        rsp_last  <= last_done;
        rsp_data  <= bus_data_in;
      end
    end
  end

  assign bus_active = (state_q != ST_IDLE);
  assign bus_oe_n   = !bus_active;
  assign bus_addr   = addr_q;

  exp_rd_csdrv #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) cs_i (
    .active (bus_active),
    .cs_idx (cs_idx_q),
    .cs_n   (bus_cs_n)
  );
endmodule

// File: rtl/exp_rd_ctrl_chk.sv
`timescale 1ns/1ps
module exp_rd_ctrl_chk #(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] bus_cs_n,
  input logic              bus_oe_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              rsp_last,
  input logic              word_done,
  input logic              last_done,
  input logic              rdy_fall
);
  localparam int STEP = DATA_W / 8;

  p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bus_cs_n) <= 1);

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (&bus_cs_n && bus_oe_n && rsp_last));

  p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_fall && !bus_oe_n) |=> !rsp_valid);

  p_burst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n && !last_done) |=> (!bus_oe_n && $stable(bus_cs_n)));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> (bus_oe_n && &bus_cs_n));

  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !last_done) |=> (bus_addr == $past(bus_addr) + ADDR_W'(STEP)));

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_oe_n && &bus_cs_n));
endmodule

bind exp_rd_ctrl exp_rd_ctrl_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs_n  (bus_cs_n),
  .bus_oe_n  (bus_oe_n),
  .bus_addr  (bus_addr),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_last  (rsp_last),
  .word_done (word_done),
  .last_done (last_done),
  .rdy_fall  (rdy_fall)
);

// File: tb/exp_rd_ctrl_tb.sv
`timescale 1ns/1ps
module exp_rd_ctrl_tb_top;
  localparam int CLK_P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cfg_nseq_ws;
  logic [23:0] cfg_seq_ws;
  logic [5:0]  cfg_seq_en;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [27:0] req_addr = '0;
  logic        req_burst = 1'b0;
  logic [3:0]  req_len = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic        rsp_last;
  logic [5:0]  bus_cs_n;
  logic [27:0] bus_addr;
  logic        bus_oe_n;
  logic [31:0] bus_data_in;
  logic        bus_rdy = 1'b1;

  int nws_b [6];
  int sws_b [6];
  bit sen_b [6];
  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [27:0] a);
    return {4'h9, a} ^ 32'h1234_5678;
  endfunction

  assign bus_data_in = mem_word(bus_addr);

  always_comb begin
    for (int c = 0; c < 6; c++) begin
      cfg_nseq_ws[c*4 +: 4] = 4'(nws_b[c]);
      cfg_seq_ws[c*4 +: 4]  = 4'(sws_b[c]);
      cfg_seq_en[c]         = sen_b[c];
    end
  end

  exp_rd_ctrl dut_i (
    .clk (clk), .rst_n (rst_n),
    .cfg_nseq_ws (cfg_nseq_ws), .cfg_seq_ws (cfg_seq_ws), .cfg_seq_en (cfg_seq_en),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .req_burst (req_burst), .req_len (req_len),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_err (rsp_err), .rsp_last (rsp_last),
    .bus_cs_n (bus_cs_n), .bus_addr (bus_addr), .bus_oe_n (bus_oe_n),
    .bus_data_in (bus_data_in), .bus_rdy (bus_rdy)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // One request; expected timing derived from wait counts and stall length.
  task automatic run_read(input int sel, input logic [24:0] low, input bit burst,
                          input int len_m1, input int stall);
    logic [27:0] a;
    int nw, t_last, k;
    int t_exp [16];
    string tag;
    a  = {3'(sel), low};
    nw = burst ? len_m1 + 1 : 1;
    @(posedge clk); #2;
    req_addr = a; req_burst = burst; req_len = 4'(len_m1); req_valid = 1'b1;
    @(posedge clk); #2;                       // accepting edge E0
    req_valid = 1'b0;
    if (sel >= 6) begin
      #3;
      chk(rsp_valid && rsp_err && rsp_last, "R3", "error response", {rsp_valid, rsp_err, rsp_last}, 3'b111);
      chk(bus_cs_n == 6'h3F && bus_oe_n, "R3", "bus quiet on error", bus_cs_n, 6'h3F);
      return;
    end
    t_exp[0] = ((nws_b[sel] > stall) ? nws_b[sel] : stall) + 1;
    for (int w = 1; w < nw; w++)
      t_exp[w] = t_exp[w-1] + (sen_b[sel] ? sws_b[sel] + 1 : nws_b[sel] + 2);
    t_last = t_exp[nw-1];
    bus_rdy = (stall == 0);
    k = 0;
    for (int i = 1; i <= t_last; i++) begin
      @(posedge clk); #5;
      if (k == 0) tag = (stall > 0) ? "R5" : "R4";
      else        tag = sen_b[sel] ? "R6" : "R7";
      if (i == t_exp[k]) begin
        chk(rsp_valid && !rsp_err, tag, "word timing", rsp_valid, 1);
        chk(rsp_data == mem_word(a + 28'(4*k)), "R10", "word data", rsp_data, mem_word(a + 28'(4*k)));
        chk(rsp_last == (k == nw-1), "R10", "last flag", rsp_last, (k == nw-1));
        k++;
      end else begin
        chk(!rsp_valid, tag, "no early word", rsp_valid, 0);
      end
      if (i < t_last) begin
        chk(bus_cs_n == ~(6'd1 << sel) && !bus_oe_n, burst ? "R8" : "R2", "selects held",
            {bus_oe_n, bus_cs_n}, {1'b0, ~(6'd1 << sel)});
        chk(!req_ready, "R11", "busy not ready", req_ready, 0);
      end else begin
        chk(bus_cs_n == 6'h3F && bus_oe_n, "R9", "release after last", {bus_oe_n, bus_cs_n}, 7'h7F);
        chk(req_ready, "R11", "ready after last", req_ready, 1);
      end
      bus_rdy = (i >= stall);
    end
    bus_rdy = 1'b1;
    chk(k == nw, "R10", "word count", k, nw);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    for (int c = 0; c < 6; c++) begin nws_b[c] = c % 4; sws_b[c] = 1; sen_b[c] = 0; end
    #(CLK_P * 3); #2;
    chk(bus_cs_n == 6'h3F && bus_oe_n && !rsp_valid && req_ready, "R1", "reset state",
        {bus_oe_n, bus_cs_n}, 7'h7F);
    rst_n = 1'b1;
    #(CLK_P * 2);
    chk(bus_cs_n == 6'h3F && bus_oe_n && !rsp_valid && req_ready, "R1", "idle after reset",
        {bus_oe_n, bus_cs_n}, 7'h7F);

    // R2: each chip select, single reads; req_len ignored for singles (R10)
    for (int c = 0; c < 6; c++) run_read(c, 25'h0_0100 + 25'(c*16), 1'b0, 5, 0);
    // R9: back-to-back singles on one select
    run_read(3, 25'h1F0, 1'b0, 0, 0);
    run_read(3, 25'h1F4, 1'b0, 0, 0);
    // R3: unmapped regions
    run_read(6, 25'h10, 1'b0, 0, 0);
    run_read(7, 25'h20, 1'b1, 3, 0);
    run_read(1, 25'h30, 1'b0, 0, 0);

    // Sweep on select 2: wait counts, sequential mode, length, stall
    foreach (nws_b[i]) ;
    for (int n = 0; n < 3; n++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 2; e++)
          for (int l = 0; l < 3; l++)
            for (int st = 0; st < 3; st++) begin
              nws_b[2] = (n == 2) ? 3 : n;
              sws_b[2] = s * 2;
              sen_b[2] = e[0];
              run_read(2, 25'h1FF_FFF0, 1'b1, (l == 2) ? 3 : l, (st == 2) ? 5 : st * 2);
            end
    // Long burst with maximum wait values
    nws_b[4] = 15; sws_b[4] = 15; sen_b[4] = 1;
    run_read(4, 25'h0, 1'b1, 15, 3);
    sen_b[4] = 0;
    run_read(4, 25'h40, 1'b1, 2, 16);
    summary();
  end
endmodule